// File: doc/BRIEF.md
# Open-Page Multi-Bank SDRAM Command Sequencer

This block takes single-word read and write requests from a host that addresses memory with a 17-bit word address. For each request it drives the SDRAM command sequence on one shared command/address bus. It keeps the row of every bank open after use, so a later access to the same row needs only the column command. A request is offered on a valid/ready handshake that carries the address, a write flag and the write data. `reqReady` stays low until every command for the accepted request has gone out.

A static mode pin selects how host address bits are split into bank, row and column. In the coarse split, each run of 128 host words lives in one bank, and the next run of 128 words lives in the next bank. In the fine split, two address bits trade places, so consecutive host words fall in different banks. The bank count is a parameter (2 or 4). Read data comes back from the external memory; the block only marks the cycle in which it is valid.

Top module: `sdram_page_seq`

## Requirements
- R1: After reset, `reqReady` is high, only `cmdNop` is asserted, `rdValid` is low, and no bank holds an open row. The first access to a bank with no open row issues activate and then read or write, with no precharge.
- R2: In coarse mode the row is host bits 16..9. The column is bits {8,6,5,4,3,2,1,0}, most significant first. Bank bit 0 is host bit 7.
- R3: In fine mode, host bits 0 and 7 trade roles: bank bit 0 is host bit 0 and column bit 0 is host bit 7. The row and the other column bits are the same as in coarse mode.
- R4: With 4 banks, bank bit 1 is host bit 8 in coarse mode and host bit 1 in fine mode.
- R5: An access whose row equals the open row of its bank issues only the read or write command.
- R6: An access to a bank whose open row is a different row issues precharge, then activate, then the read or write, all on that bank.
- R7: Rows stay open after an access. Each bank keeps its own open row, so accesses to other banks in between do not close it.
- R8: At most one command is asserted per cycle, and `cmdNop` is high in every other cycle. Precharge and activate each take a 2-cycle slot, and read or write takes a 3-cycle slot; the command strobe is in the first cycle of its slot. During activate `cmdAddr` carries the row, and during read or write it carries the column.
- R9: `reqReady` is low from the cycle after a request is accepted until the last slot of its sequence has ended.
- R10: `rdValid` is high only in the last cycle of a read slot. `memWdata` carries the write data of the request while the write command is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fineMode | input | 1 | 0: 128-word bank interleave, 1: 1-word bank interleave (static) |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be accepted |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Host word address |
| reqWdata | input | DATA_W | Write data |
| cmdAct | output | 1 | Bank activate strobe |
| cmdPre | output | 1 | Precharge strobe |
| cmdRd | output | 1 | Read strobe |
| cmdWr | output | 1 | Write strobe |
| cmdNop | output | 1 | No command this cycle |
| cmdBank | output | log2(NUM_BANKS) | Bank select |
| cmdAddr | output | 8 | Row (activate) or column (read/write) |
| memWdata | output | DATA_W | Write data to memory |
| rdValid | output | 1 | Read data valid on memory data bus |

## Verification
On every cycle the assertions check that the command strobes are one-hot or idle, that no slot is cut short, and that a precharge is followed by an activate two cycles later. They also check that activate goes only to a bank with no open row, that column commands go only to an open, matching row, that `rdValid` comes two cycles after the read strobe, and that acceptance drops `reqReady`. Only the bench scenarios can show that the address split is right for each mode, that the open-row state gives hit, closed and conflict sequences in the right cases across interleaved banks, and that data written under one host address reads back under the same address through a behavioural memory.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_ACT, ST_ACC} seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch request this cycle
    logic doPre;    // precharge issued this cycle
    logic doAct;    // activate issued this cycle
    logic doAcc;    // read/write issued this cycle
  } seqStrobe_t;
endpackage

// File: rtl/sdram_seq_datapath.sv
module sdram_seq_datapath
  import sdram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 17,
  parameter int MA_W      = 8,
  parameter int DATA_W    = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fineMode,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  seqStrobe_t        strobe,
  output logic              lookupOpen,
  output logic              lookupHit,
  output logic              curWrite,
  output logic [BANK_W-1:0] cmdBank,
  output logic [MA_W-1:0]   cmdAddr,
  output logic [DATA_W-1:0] memWdata
);
  localparam int ROW_LSB = ADDR_W - MA_W;

  logic [BANK_W-1:0] newBank;
  logic [MA_W-1:0]   newRow, newCol;
  logic [BANK_W-1:0] curBank;
  logic [MA_W-1:0]   curRow, curCol;
  logic [NUM_BANKS-1:0] openValid;
  logic [MA_W-1:0]   openRow [NUM_BANKS];

  // Address split: fine mode swaps host bits 0 and 7
  if (NUM_BANKS == 4) begin : g_bank4
    assign newBank = fineMode ? {reqAddr[1], reqAddr[0]} : {reqAddr[8], reqAddr[7]};
  end else begin : g_bank2
    assign newBank = fineMode ? reqAddr[0] : reqAddr[7];
  end
  assign newRow = reqAddr[ADDR_W-1:ROW_LSB];
  assign newCol = fineMode ? {reqAddr[8], reqAddr[6:1], reqAddr[7]}
                           : {reqAddr[8], reqAddr[6:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curBank  <= '0;
      curRow   <= '0;
      curCol   <= '0;
      curWrite <= 1'b0;
      memWdata <= '0;
    end else if (strobe.capture) begin
      curBank  <= newBank;
      curRow   <= newRow;
      curCol   <= newCol;
      curWrite <= reqWrite;
      memWdata <= reqWdata;
    end
  end

  // One open row per bank
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      openValid <= '0;
      for (int i = 0; i < NUM_BANKS; i++) openRow[i] <= '0;
    end else begin
      if (strobe.doPre) openValid[curBank] <= 1'b0;
      if (strobe.doAct) begin
        openValid[curBank] <= 1'b1;
        openRow[curBank]   <= curRow;
      end
    end
  end

  assign lookupOpen = openValid[newBank];
  assign lookupHit  = lookupOpen && (openRow[newBank] == newRow);
  assign cmdBank    = curBank;
  assign cmdAddr    = strobe.doAct ? curRow : (strobe.doAcc ? curCol : '0);

  // R6: activate only reaches a bank that holds no open row
  p_act_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doAct |-> !openValid[curBank]);
  // R5: column commands only reach the matching open row
  p_acc_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doAcc |-> (openValid[curBank] && openRow[curBank] == curRow));
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int PRE_CLKS = 2,
  parameter int ACT_CLKS = 2,
  parameter int ACC_CLKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       lookupOpen,
  input  logic       lookupHit,
  input  logic       curWrite,
  output logic       reqReady,
  output seqStrobe_t strobe,
  output logic       cmdAct,
  output logic       cmdPre,
  output logic       cmdRd,
  output logic       cmdWr,
  output logic       cmdNop,
  output logic       rdValid
);
  localparam int MAX_CLKS = (ACC_CLKS > PRE_CLKS) ?
                            ((ACC_CLKS > ACT_CLKS) ? ACC_CLKS : ACT_CLKS) :
                            ((PRE_CLKS > ACT_CLKS) ? PRE_CLKS : ACT_CLKS);
  localparam int CNT_W = $clog2(MAX_CLKS) + 1;

  seqState_t state;
  logic [CNT_W-1:0] slotCnt, slotLen;
  logic slotFirst, slotLast, accept;

  always_comb begin
    case (state)
      ST_PRE:  slotLen = CNT_W'(PRE_CLKS);
      ST_ACT:  slotLen = CNT_W'(ACT_CLKS);
      ST_ACC:  slotLen = CNT_W'(ACC_CLKS);
      default: slotLen = CNT_W'(1);
    endcase
  end

  assign slotFirst = (slotCnt == '0);
  assign slotLast  = (slotCnt == slotLen - CNT_W'(1));
  assign reqReady  = (state == ST_IDLE);
  assign accept    = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      slotCnt <= '0;
    end else if (state == ST_IDLE) begin
      slotCnt <= '0;
      if (accept) state <= !lookupOpen ? ST_ACT : (lookupHit ? ST_ACC : ST_PRE);
    end else if (slotLast) begin
      slotCnt <= '0;
      case (state)
        ST_PRE:  state <= ST_ACT;
        ST_ACT:  state <= ST_ACC;
        default: state <= ST_IDLE;
      endcase
    end else begin
      slotCnt <= slotCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobe.capture = accept;
    strobe.doPre   = (state == ST_PRE) && slotFirst;
    strobe.doAct   = (state == ST_ACT) && slotFirst;
    strobe.doAcc   = (state == ST_ACC) && slotFirst;
  end

  assign cmdPre  = strobe.doPre;
  assign cmdAct  = strobe.doAct;
  assign cmdRd   = strobe.doAcc && !curWrite;
  assign cmdWr   = strobe.doAcc && curWrite;
  assign cmdNop  = !(cmdPre || cmdAct || cmdRd || cmdWr);
  assign rdValid = (state == ST_ACC) && slotLast && !curWrite;

  // R8: one command per cycle on the shared bus
  p_one_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmdAct, cmdPre, cmdRd, cmdWr}));
  // R8: a row command is followed by an idle bus cycle
  p_row_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdAct || cmdPre) |=> cmdNop);
  // R6: precharge is followed by activate two cycles later
  p_pre_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmdPre |=> ##1 cmdAct);
  // R9: acceptance makes the block busy
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !reqReady);
  // R10: read data valid two cycles after the read strobe
  p_rdvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmdRd |=> ##1 rdValid);
endmodule

// File: rtl/sdram_page_seq.sv
module sdram_page_seq
  import sdram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 17,
  parameter int MA_W      = 8,
  parameter int DATA_W    = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fineMode,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              cmdAct,
  output logic              cmdPre,
  output logic              cmdRd,
  output logic              cmdWr,
  output logic              cmdNop,
  output logic [BANK_W-1:0] cmdBank,
  output logic [MA_W-1:0]   cmdAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              rdValid
);
  seqStrobe_t strobe;
  logic lookupOpen, lookupHit, curWrite;

  sdram_seq_ctrl u_ctrl (
    .clk, .rst_n, .reqValid, .lookupOpen, .lookupHit, .curWrite,
    .reqReady, .strobe, .cmdAct, .cmdPre, .cmdRd, .cmdWr, .cmdNop, .rdValid
  );

  sdram_seq_datapath #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .MA_W(MA_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk, .rst_n, .fineMode, .reqAddr, .reqWrite, .reqWdata, .strobe,
    .lookupOpen, .lookupHit, .curWrite, .cmdBank, .cmdAddr, .memWdata
  );
endmodule

// File: tb/sdram_page_seq_tb.sv
module sdram_page_seq_tb;
  localparam int CMD_NOP = 0, CMD_ACT = 1, CMD_PRE = 2, CMD_RD = 3, CMD_WR = 4, CMD_BAD = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fineMode = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic reqReady, cmdAct, cmdPre, cmdRd, cmdWr, cmdNop, rdValid;
  logic [1:0] cmdBank;
  logic [7:0] cmdAddr;
  logic [15:0] memWdata;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic [15:0] hostMem [int];
  logic [15:0] devMem [int];
  logic       modelValid [4];
  logic [7:0] modelRow [4];
  logic [7:0] seenRow [4];

  always #4 clk = ~clk;

  sdram_page_seq u_dut (
    .clk, .rst_n, .fineMode, .reqValid, .reqReady, .reqWrite, .reqAddr, .reqWdata,
    .cmdAct, .cmdPre, .cmdRd, .cmdWr, .cmdNop, .cmdBank, .cmdAddr, .memWdata, .rdValid
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: act %0d cycles exp <= 150000", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
    end
  endtask

  function automatic int expBank(input logic [16:0] a);
    return fineMode ? {a[1], a[0]} : {a[8], a[7]};
  endfunction
  function automatic int expCol(input logic [16:0] a);
    return fineMode ? {a[8], a[6:1], a[7]} : {a[8], a[6:0]};
  endfunction

  function automatic int cmdCode();
    int n = int'(cmdAct) + int'(cmdPre) + int'(cmdRd) + int'(cmdWr);
    if (n > 1 || (n == 1 && cmdNop) || (n == 0 && !cmdNop)) return CMD_BAD;
    if (cmdAct) return CMD_ACT;
    if (cmdPre) return CMD_PRE;
    if (cmdRd)  return CMD_RD;
    if (cmdWr)  return CMD_WR;
    return CMD_NOP;
  endfunction

  task automatic doReset(input logic fine);
    @(negedge clk);
    rst_n = 1'b0; fineMode = fine; reqValid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin modelValid[i] = 1'b0; modelRow[i] = '0; seenRow[i] = '0; end
    hostMem.delete(); devMem.delete();
    @(negedge clk);
    check(reqReady && cmdNop && !rdValid && !cmdAct && !cmdPre && !cmdRd && !cmdWr,
          "R1", "reset outputs", {reqReady, cmdNop, rdValid}, 3'b110);
  endtask

  task automatic access(input logic [16:0] a, input logic wr, input logic [15:0] wd);
    int b = expBank(a);
    int row = int'(a[16:9]);
    int col = expCol(a);
    int expSeq[8];
    int expN = 0;
    int gotSeq[16];
    int n = 0;
    int guard = 0;
    bit addrOk = 1'b1;
    bit rdvOk = 1'b1;
    bit seqOk;
    int badAddr = 0;
    int rdKey = 0;
    logic [15:0] rdData = 16'hDEAD;
    string kindTag;
    if (!modelValid[b]) begin
      kindTag = "R1";
      expSeq[0] = CMD_ACT; expSeq[1] = CMD_NOP; expN = 2;
    end else if (modelRow[b] != row[7:0]) begin
      kindTag = "R6";
      expSeq[0] = CMD_PRE; expSeq[1] = CMD_NOP; expSeq[2] = CMD_ACT; expSeq[3] = CMD_NOP; expN = 4;
    end else begin
      kindTag = "R5";
    end
    expSeq[expN] = wr ? CMD_WR : CMD_RD; expSeq[expN+1] = CMD_NOP; expSeq[expN+2] = CMD_NOP;
    expN += 3;

    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = wr; reqWdata = wd;
    while (!reqReady && guard < 50) begin @(negedge clk); guard++; end
    @(negedge clk);
    reqValid = 1'b0;
    while (!reqReady && n < 16) begin
      gotSeq[n] = cmdCode();
      if (gotSeq[n] == CMD_ACT) begin
        seenRow[cmdBank] = cmdAddr;
        if (int'(cmdBank) != b || int'(cmdAddr) != row) begin addrOk = 1'b0; badAddr = {cmdBank, cmdAddr}; end
      end
      if (gotSeq[n] == CMD_PRE && int'(cmdBank) != b) begin addrOk = 1'b0; badAddr = {cmdBank, cmdAddr}; end
      if (gotSeq[n] == CMD_WR || gotSeq[n] == CMD_RD) begin
        if (int'(cmdBank) != b || int'(cmdAddr) != col) begin addrOk = 1'b0; badAddr = {cmdBank, cmdAddr}; end
        rdKey = {cmdBank, seenRow[cmdBank], cmdAddr};
        if (gotSeq[n] == CMD_WR) devMem[rdKey] = memWdata;
      end
      if (rdValid) begin
        if (wr || n != expN - 1) rdvOk = 1'b0;
        else if (devMem.exists(rdKey)) rdData = devMem[rdKey];
      end else if (!wr && n == expN - 1) rdvOk = 1'b0;
      n++;
      @(negedge clk);
    end

    seqOk = (n == expN);
    for (int i = 0; i < expN && i < n; i++) if (gotSeq[i] != expSeq[i]) seqOk = 1'b0;
    check(seqOk, kindTag, "command sequence (R8 R9)", n, expN);
    check(addrOk, fineMode ? "R3" : "R2", "bank/row/col (R4)", badAddr, (b << 8) | col);
    modelValid[b] = 1'b1; modelRow[b] = row[7:0];
    if (wr) hostMem[int'(a)] = wd;
    else begin
      check(rdvOk, "R10", "rdValid slot position", int'(rdvOk), 1);
      if (hostMem.exists(int'(a)))
        check(rdData == hostMem[int'(a)], "R10", "read data", int'(rdData), int'(hostMem[int'(a)]));
    end
  endtask

  task automatic runMode(input logic fine);
    logic [16:0] a;
    doReset(fine);
    // Directed: closed, hit, other bank, hit again after interleave, conflict
    access(17'h00000, 1'b1, 16'h1111);   // R1 closed bank
    access(17'h00000, 1'b0, 16'h0);      // R5 hit
    access(17'h00080, 1'b1, 16'h2222);
    access(17'h00002, 1'b1, 16'h3333);   // R7 row kept open across banks
    access(17'h00200, 1'b1, 16'h4444);   // R6 conflict
    access(17'h00000, 1'b0, 16'h0);      // R6 back to first row
    access(17'h00180, 1'b1, 16'h5555);   // R4 upper bank bit
    access(17'h1FFFF, 1'b1, 16'h6666);
    access(17'h1FFFF, 1'b0, 16'h0);
    // Contiguous run across a 128-word boundary, then strided sweep
    for (int i = 0; i < 40; i++) begin
      a = 17'(120 + i);
      access(a, 1'b1, 16'(a) ^ 16'hA5A5);
    end
    for (int i = 0; i < 160; i++) begin
      a = 17'((i * 4099 + i * i * 7) % 131072);
      access(a, 1'b1, 16'(a) ^ 16'h5A0F ^ 16'(fine));
    end
    for (int i = 0; i < 40; i++) begin
      a = 17'(120 + i);
      access(a, 1'b0, 16'h0);
    end
    for (int i = 159; i >= 0; i--) begin
      a = 17'((i * 4099 + i * i * 7) % 131072);
      access(a, 1'b0, 16'h0);
    end
  endtask

  initial begin
    runMode(1'b0);
    runMode(1'b1);
    summary();
  end
endmodule